// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host side of a hardware cursor generator. A host reaches the generator through four ports spaced one bus word apart, selected by a 2-bit port number: pointer low byte, pointer high byte, pattern word and control register. A single 16-bit pointer selects the target of every data access. The port that carries the access decides what the pointer addresses. Through the control register port it addresses thirteen byte-wide control registers. Through the pattern port it addresses a 512-word cursor pattern memory. Each access through either data port advances the pointer by one, so a host can stream a run of registers or pattern words after loading the pointer once.

The control registers drive the cursor generator directly. These are a command byte and six 12-bit coordinates: cursor X and Y, and crosshair window X, Y, width and height. A second read port on the pattern memory serves the pixel engine. Host accesses arrive as a valid/ready request stream. Reads return a response stream with its own valid/ready pair. The request side is held off (ready low) while a read response is waiting and the response ready input is low. A request is taken on any clock edge where request valid and ready are both high. Writes produce no response.

Top module: `cursor_host_port`

## Requirements
- R1: After reset the command output and all six coordinate outputs are zero, the pointer is 0x0000, no response is pending and hst_ready is high.
- R2: A write to port 0 loads pointer bits 7:0 from hst_wdata[7:0], and a write to port 1 loads pointer bits 15:8 from hst_wdata[7:0]. Reads of ports 0 and 1 return the matching pointer byte in rsp_data[7:0] with bits 15:8 zero. No access to port 0 or 1 moves the pointer.
- R3: A write to port 3 stores hst_wdata[7:0] into the control register selected by the pointer. Bits 15:8 of the write word are ignored. The pointer then advances by one.
- R4: A read of port 3 returns the selected register in rsp_data[7:0] with rsp_data[15:8] zero, and the pointer advances by one.
- R5: Register index 0 is the command byte (cmd_out). The coordinates each take a pair of registers, low byte at the lower index: 1/2 cursor X, 3/4 cursor Y, 5/6 window X, 7/8 window Y, 9/10 window width, 11/12 window height. Each coordinate output is {high[3:0], low[7:0]}.
- R6: The high-byte registers (even indices 2 to 12) keep only bits 3:0. A read of one of them returns bits 7:4 as zero.
- R7: A port 3 access with the pointer above 0x000C changes no register and reads as zero, and the pointer still advances.
- R8: A write to port 2 stores the whole 16-bit word (mask byte in 15:8, data byte in 7:0) at pattern address pointer[8:0] when the pointer is 0x0000 to 0x01FF. A read of port 2 returns that word. The pointer then advances. The video port returns the word at vid_addr one cycle after vid_addr is presented.
- R9: A port 2 access with the pointer above 0x01FF writes nothing, with no aliasing into the pattern memory, and reads as zero. The pointer still advances.
- R10: The pointer wraps from 0xFFFF to 0x0000 when it advances.
- R11: A read accepted on one edge gives rsp_valid high with its data after that edge. While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data hold steady and hst_ready stays low, so no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host request valid |
| hst_ready | output | 1 | Host request may be taken |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_port | input | 2 | 0 pointer low, 1 pointer high, 2 pattern, 3 control register |
| hst_wdata | input | 16 | Write word; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 16 | Read response word |
| cmd_out | output | 8 | Command register |
| cur_x | output | 12 | Cursor X |
| cur_y | output | 12 | Cursor Y |
| win_x | output | 12 | Crosshair window X |
| win_y | output | 12 | Crosshair window Y |
| win_w | output | 12 | Crosshair window width |
| win_h | output | 12 | Crosshair window height |
| vid_addr | input | 9 | Pattern read address for the pixel engine |
| vid_data | output | 16 | Pattern word, one cycle after vid_addr |

## Verification
The auto-increment is tested with streamed runs that cross a low/high register pair and fill all eight window registers. A wrong step or a swapped pair shows up as a misplaced coordinate nibble. Write words with different upper and lower bytes show whether the right byte lane is used. The high-nibble masking is tested by reading back a high register. Pointers at 0x000D, 0x0200 and 0xFFFF test the edge of each target range and the wrap. A known pattern word at address 0 shows that an out-of-range pattern write does not alias into memory. A held response with an extra request presented shows that back-pressure stops both the pointer and the register update.

// File: rtl/cursor_host_pkg.sv
package cursor_host_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_PATTERN = 2'd2,
    PORT_REGS    = 2'd3
  } host_port_e;
endpackage

// File: rtl/cursor_ptr.sv
module cursor_ptr #(
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              step,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [PTR_W-1:0]  ptr
);
  localparam int HI_W = PTR_W - BYTE_W;

  // Loads and steps never coincide: one access per cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (ld_lo) ptr[BYTE_W-1:0] <= byte_in;
    else if (ld_hi) ptr[PTR_W-1:BYTE_W] <= byte_in[HI_W-1:0];
    else if (step)  ptr <= ptr + 1'b1;   // natural wrap at all-ones
  end
endmodule

// File: rtl/cursor_regfile.sv
module cursor_regfile #(
  parameter int PTR_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int COORD_W   = 12,
  parameter int REG_COUNT = 13,
  localparam int COORD_COUNT = (REG_COUNT - 1) / 2,
  localparam int HI_BITS     = COORD_W - BYTE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [PTR_W-1:0]               idx,
  input  logic [BYTE_W-1:0]              wbyte,
  output logic [BYTE_W-1:0]              rbyte,
  output logic [BYTE_W-1:0]              cmd_out,
  output logic [COORD_COUNT*COORD_W-1:0] coord_flat
);
  logic [BYTE_W-1:0] regs [REG_COUNT];

  // High-byte registers sit at even non-zero indices and keep HI_BITS bits.
  function automatic logic [BYTE_W-1:0] keep_mask(input int i);
    if (i > 0 && (i % 2) == 0) return BYTE_W'((1 << HI_BITS) - 1);
    return '1;
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_COUNT; i++) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && idx == PTR_W'(i))
        regs[i] <= wbyte & keep_mask(i);
    end
  end

  // An index past the last register matches nothing and reads as zero.
  always_comb begin
    rbyte = '0;
    for (int i = 0; i < REG_COUNT; i++)
      if (idx == PTR_W'(i)) rbyte = regs[i];
  end

  assign cmd_out = regs[0];

  for (genvar k = 0; k < COORD_COUNT; k++) begin : g_coord
    assign coord_flat[k*COORD_W +: COORD_W] =
      {regs[2*k+2][HI_BITS-1:0], regs[2*k+1]};
  end
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [AW-1:0]     vid_addr,
  output logic [WORD_W-1:0] vid_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
    vid_data <= mem[vid_addr];
  end
endmodule

// File: rtl/cursor_host_port.sv
module cursor_host_port
  import cursor_host_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int COORD_W   = 12,
  parameter int REG_COUNT = 13,
  parameter int MAP_DEPTH = 512,
  localparam int MAP_AW      = $clog2(MAP_DEPTH),
  localparam int COORD_COUNT = (REG_COUNT - 1) / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_valid,
  output logic               hst_ready,
  input  logic               hst_write,
  input  logic [1:0]         hst_port,
  input  logic [WORD_W-1:0]  hst_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_data,
  output logic [BYTE_W-1:0]  cmd_out,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic [COORD_W-1:0] win_x,
  output logic [COORD_W-1:0] win_y,
  output logic [COORD_W-1:0] win_w,
  output logic [COORD_W-1:0] win_h,
  input  logic [MAP_AW-1:0]  vid_addr,
  output logic [WORD_W-1:0]  vid_data
);
  host_port_e port_e;
  logic accept, is_reg, is_map, map_ok;
  logic [PTR_W-1:0] ptr;
  logic [BYTE_W-1:0] reg_rbyte, byte_src;
  logic [WORD_W-1:0] ram_q;
  logic [COORD_COUNT*COORD_W-1:0] coord_flat;
  logic rsp_valid_q, rsp_from_ram, map_ok_q;
  logic [BYTE_W-1:0] rsp_byte_q;

  assign port_e    = host_port_e'(hst_port);
  assign hst_ready = !rsp_valid_q || rsp_ready;
  assign accept    = hst_valid && hst_ready;
  assign is_reg    = (port_e == PORT_REGS);
  assign is_map    = (port_e == PORT_PATTERN);
  assign map_ok    = (ptr < PTR_W'(MAP_DEPTH));

  cursor_ptr #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (accept && hst_write && port_e == PORT_ADDR_LO),
    .ld_hi   (accept && hst_write && port_e == PORT_ADDR_HI),
    .step    (accept && (is_reg || is_map)),
    .byte_in (hst_wdata[BYTE_W-1:0]),
    .ptr     (ptr)
  );

  cursor_regfile #(
    .PTR_W(PTR_W), .BYTE_W(BYTE_W), .COORD_W(COORD_W), .REG_COUNT(REG_COUNT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (accept && hst_write && is_reg),
    .idx        (ptr),
    .wbyte      (hst_wdata[BYTE_W-1:0]),
    .rbyte      (reg_rbyte),
    .cmd_out    (cmd_out),
    .coord_flat (coord_flat)
  );

  cursor_pattern_ram #(.WORD_W(WORD_W), .DEPTH(MAP_DEPTH)) u_map (
    .clk      (clk),
    .wr_en    (accept && hst_write && is_map && map_ok),
    .wr_addr  (ptr[MAP_AW-1:0]),
    .wr_data  (hst_wdata),
    .rd_en    (accept && !hst_write && is_map),
    .rd_addr  (ptr[MAP_AW-1:0]),
    .rd_data  (ram_q),
    .vid_addr (vid_addr),
    .vid_data (vid_data)
  );

  assign cur_x = coord_flat[0*COORD_W +: COORD_W];
  assign cur_y = coord_flat[1*COORD_W +: COORD_W];
  assign win_x = coord_flat[2*COORD_W +: COORD_W];
  assign win_y = coord_flat[3*COORD_W +: COORD_W];
  assign win_w = coord_flat[4*COORD_W +: COORD_W];
  assign win_h = coord_flat[5*COORD_W +: COORD_W];

  always_comb begin
    unique case (port_e)
      PORT_ADDR_LO: byte_src = ptr[BYTE_W-1:0];
      PORT_ADDR_HI: byte_src = BYTE_W'(ptr[PTR_W-1:BYTE_W]);
      default:      byte_src = reg_rbyte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_from_ram <= 1'b0;
      map_ok_q     <= 1'b0;
      rsp_byte_q   <= '0;
    end else if (accept && !hst_write) begin
      rsp_valid_q  <= 1'b1;
      rsp_from_ram <= is_map;
      map_ok_q     <= map_ok;
      rsp_byte_q   <= byte_src;
    end else if (rsp_ready) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = !rsp_from_ram ? {{(WORD_W-BYTE_W){1'b0}}, rsp_byte_q}
                   : (map_ok_q ? ram_q : '0);
endmodule

// File: rtl/cursor_host_chk.sv
module cursor_host_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_valid,
  input logic             hst_ready,
  input logic             hst_write,
  input logic [1:0]       hst_port,
  input logic [15:0]      hst_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [15:0]      rsp_data,
  input logic [PTR_W-1:0] ptr,
  input logic [7:0]       cmd_out,
  input logic [11:0]      cur_x,
  input logic [11:0]      cur_y
);
  logic acc;
  assign acc = hst_valid && hst_ready;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));  // R11
  AST_NO_TAKE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !hst_ready);  // R11
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && hst_port[1] |=> ptr == PTR_W'($past(ptr) + 1'b1));  // R10
  AST_PTR_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && hst_write && hst_port == 2'd0 |=>
      ptr[7:0] == $past(hst_wdata[7:0]) && ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8]));  // R2
  AST_REG_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !hst_write && hst_port == 2'd3 |=> rsp_valid && rsp_data[15:8] == 8'h00);  // R4
  AST_OOR_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && hst_write && hst_port == 2'd3 && ptr > PTR_W'(12) |=>
      $stable(cmd_out) && $stable(cur_x) && $stable(cur_y));  // R7
endmodule

bind cursor_host_port cursor_host_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
  .hst_write(hst_write), .hst_port(hst_port), .hst_wdata(hst_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .ptr(ptr), .cmd_out(cmd_out), .cur_x(cur_x), .cur_y(cur_y)
);

// File: tb/sim_cursor_host_port.sv
`timescale 1ns/1ps
module sim_cursor_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_valid = 1'b0, hst_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] hst_port = 2'd0;
  logic [15:0] hst_wdata = '0;
  logic [8:0] vid_addr = '0;
  logic hst_ready, rsp_valid;
  logic [15:0] rsp_data, vid_data;
  logic [7:0] cmd_out;
  logic [11:0] cur_x, cur_y, win_x, win_y, win_w, win_h;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cursor_host_port u0 (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
    .hst_write(hst_write), .hst_port(hst_port), .hst_wdata(hst_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cmd_out(cmd_out), .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x),
    .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .vid_addr(vid_addr), .vid_data(vid_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // One accepted access; q holds the read response (or 16'hDEAD if none).
  task automatic access(input logic [1:0] p, input logic w,
                        input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = w; hst_port = p; hst_wdata = d;
    @(posedge clk);
    @(negedge clk);
    hst_valid = 1'b0;
    q = (!w && rsp_valid) ? rsp_data : 16'hDEAD;
  endtask

  task automatic wr8(input logic [1:0] p, input logic [7:0] b);
    logic [15:0] q;
    access(p, 1'b1, {b, b}, q);
  endtask

  task automatic rd(input logic [1:0] p, output logic [15:0] q);
    access(p, 1'b0, 16'h0000, q);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr8(2'd0, a[7:0]);
    wr8(2'd1, a[15:8]);
  endtask

  task automatic check_ptr(input string req, input logic [15:0] exp);
    logic [15:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    check(req, "pointer", {hi[7:0], lo[7:0]}, exp);
  endtask

  task automatic t_reset;
    check("R1", "cmd_out", cmd_out, 0);
    check("R1", "coords", {cur_x, cur_y, win_x, win_y, win_w, win_h}, 0);
    check("R1", "rsp_valid", rsp_valid, 0);
    check("R1", "hst_ready", hst_ready, 1);
    check_ptr("R1", 16'h0000);
  endtask

  task automatic t_pointer_ports;
    logic [15:0] q;
    set_ptr(16'h1234);
    rd(2'd0, q); check("R2", "ptr low read", q, 16'h0034);
    rd(2'd1, q); check("R2", "ptr high read", q, 16'h0012);
    rd(2'd0, q); check("R2", "ptr unchanged by address reads", q, 16'h0034);
  endtask

  task automatic t_cursor_stream;
    logic [15:0] q;
    set_ptr(16'h0001);
    wr8(2'd3, 8'h34); wr8(2'd3, 8'hA2); wr8(2'd3, 8'h78); wr8(2'd3, 8'hF5);
    check("R5", "cur_x", cur_x, 12'h234);
    check("R6", "cur_y high nibble only", cur_y, 12'h578);
    check_ptr("R3", 16'h0005);
    set_ptr(16'h0000);
    access(2'd3, 1'b1, 16'hAA41, q);
    check("R3", "cmd uses low byte lane", cmd_out, 8'h41);
  endtask

  task automatic t_window;
    set_ptr(16'h0005);
    wr8(2'd3, 8'h11); wr8(2'd3, 8'h0A); wr8(2'd3, 8'h22); wr8(2'd3, 8'h0B);
    wr8(2'd3, 8'h33); wr8(2'd3, 8'h0C); wr8(2'd3, 8'h44); wr8(2'd3, 8'h0D);
    check("R5", "window x/y/w/h", {win_x, win_y, win_w, win_h}, 48'hA11B22C33D44);
  endtask

  task automatic t_reg_read;
    logic [15:0] q;
    set_ptr(16'h0002);
    rd(2'd3, q); check("R6", "high reg read masked", q, 16'h0002);
    rd(2'd3, q); check("R4", "next reg read", q, 16'h0078);
    check_ptr("R4", 16'h0004);
  endtask

  task automatic t_out_of_range;
    logic [15:0] q;
    set_ptr(16'h000D);
    wr8(2'd3, 8'hFF);
    check("R7", "regs unchanged", {cmd_out, cur_x, cur_y}, {8'h41, 12'h234, 12'h578});
    check("R7", "window unchanged", {win_x, win_y, win_w, win_h}, 48'hA11B22C33D44);
    rd(2'd3, q); check("R7", "read past last reg", q, 16'h0000);
    check_ptr("R7", 16'h000F);
  endtask

  task automatic t_pattern;
    logic [15:0] q;
    set_ptr(16'h0000);
    access(2'd2, 1'b1, 16'h5AA5, q);
    set_ptr(16'h01FE);
    access(2'd2, 1'b1, 16'hA55A, q);
    access(2'd2, 1'b1, 16'h1234, q);
    access(2'd2, 1'b1, 16'hFFFF, q);
    check_ptr("R9", 16'h0201);
    set_ptr(16'h01FE);
    rd(2'd2, q); check("R8", "pattern read 0x1FE", q, 16'hA55A);
    rd(2'd2, q); check("R8", "pattern read 0x1FF", q, 16'h1234);
    rd(2'd2, q); check("R9", "pattern read past end", q, 16'h0000);
    @(negedge clk); vid_addr = 9'h000;
    @(posedge clk); @(negedge clk);
    check("R9", "word 0 not aliased", vid_data, 16'h5AA5);
    vid_addr = 9'h1FF;
    @(posedge clk); @(negedge clk);
    check("R8", "video port word", vid_data, 16'h1234);
  endtask

  task automatic t_wrap;
    set_ptr(16'hFFFF);
    wr8(2'd3, 8'h99);
    check("R10", "cmd not hit at 0xFFFF", cmd_out, 8'h41);
    check_ptr("R10", 16'h0000);
    wr8(2'd3, 8'h66);
    check("R10", "write after wrap lands at 0", cmd_out, 8'h66);
  endtask

  task automatic t_backpressure;
    set_ptr(16'h0003);
    @(negedge clk);
    rsp_ready = 1'b0;
    hst_valid = 1'b1; hst_write = 1'b0; hst_port = 2'd3;
    @(posedge clk); @(negedge clk);
    hst_valid = 1'b0;
    check("R11", "response valid", rsp_valid, 1);
    check("R11", "response data", rsp_data, 16'h0078);
    check("R11", "ready low while held", hst_ready, 0);
    hst_valid = 1'b1; hst_write = 1'b1; hst_port = 2'd3; hst_wdata = 16'h0909;
    @(posedge clk); @(negedge clk);
    hst_valid = 1'b0;
    check("R11", "still held", {rsp_valid, rsp_data}, {1'b1, 16'h0078});
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11", "response taken", {rsp_valid, hst_ready}, 2'b01);
    check("R11", "blocked write had no effect", cur_y, 12'h578);
    check_ptr("R11", 16'h0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pointer_ports();
    t_cursor_stream();
    t_window();
    t_reg_read();
    t_out_of_range();
    t_pattern();
    t_wrap();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R11 watchdog: got=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule